// File: doc/BRIEF.md
# Packet Buffer Allocation Unit

This block manages ownership of a small pool of numbered packet buffers inside an Ethernet controller. Each buffer number is always in exactly one place. It can sit in the free map, in the transmit queue, in the receive queue, or it can be held by the host. The host drives everything through an 8-bit command word and a packet number register. It can allocate a buffer for transmission, queue a filled buffer for sending, take or discard the head of the receive queue, return a named buffer, drain the transmit queue, or return the whole pool to its initial state.

The transmit side removes finished packets from the transmit queue head with a pop strobe, and each popped buffer goes back to the free map. The receive side signals a completed frame with a push strobe. The unit then claims the lowest free buffer for that frame and appends it to the receive queue. When the pool is empty the frame is dropped and an overrun flag is raised. Allocation results, queue heads, empty flags, a busy bit and masked interrupt status appear as plain output ports.

Top module: `pkt_alloc_unit`

## Requirements
- R1: The command is decoded from bits 7:5 of `cmd_word` only; bits 4:0 have no effect. Codes: 0 no-op, 1 allocate, 2 full reset, 3 remove RX head, 4 remove and free RX head, 5 free the number in the packet number register, 6 enqueue that number on the TX queue, 7 drain the TX queue.
- R2: An allocate with a free buffer writes the lowest free number to `alloc_result` with bit 7 clear, sets `int_status` bit 3, and hands the buffer to the host.
- R3: An allocate with no free buffer sets `alloc_result` to 0x80 and clears `int_status` bit 3.
- R4: Enqueue appends the register number to the TX queue. `fifo_status[6:0]` shows the TX head, and bit 7 is set when the TX queue is empty. `tx_pop` removes the head in order and frees it.
- R5: `rx_push` claims the lowest free number and appends it to the RX queue. `fifo_status[14:8]` shows the RX head, and bit 15 is set when the RX queue is empty. With no free buffer, nothing is queued and `int_status` bit 4 is set.
- R6: Command 3 removes the RX head without freeing it, so the host owns it. Command 4 removes the RX head and frees it.
- R7: Command 5 frees the number held in the packet number register.
- R8: Command 2 frees every buffer, empties both queues, and clears `int_status` bits 3 and 4.
- R9: Command 7 pops and frees one TX entry per cycle. `busy` stays high for the entry count plus one cycles, and `tx_pop` is ignored meanwhile.
- R10: Commands 2, 4 and 5 hold `busy` high for REL_LAT cycles after the command cycle. Any command offered while `busy` is high is ignored.
- R11: `int_status` bit 0 is high while the RX queue is non-empty. A 1 written through `ack_wdata` clears bit 3 or bit 4. `irq` is high when any status bit has its `int_mask` bit set.
- R12: When `rx_push` and an allocate arrive in the same cycle, the receive side gets the lowest free number and the host gets the next one.
- R13: `pnr_wr` loads `pnr_wdata` into the packet number register, which reads back on `pnr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_word | input | 8 | Command word, code in bits 7:5 |
| pnr_wr | input | 1 | Packet number register write |
| pnr_wdata | input | 8 | Packet number write data |
| mask_wr | input | 1 | Interrupt mask write |
| mask_wdata | input | 8 | Interrupt mask data |
| ack_wr | input | 1 | Interrupt acknowledge strobe |
| ack_wdata | input | 8 | Status bits to clear |
| rx_push | input | 1 | Receive side completed a frame |
| tx_pop | input | 1 | Transmit side finished the TX head |
| alloc_result | output | 8 | Last allocation: bit 7 failed, low bits number |
| pnr | output | 8 | Packet number register |
| fifo_status | output | 16 | RX empty/head in high byte, TX empty/head in low byte |
| busy | output | 1 | Release, reset or drain in progress |
| int_status | output | 8 | Interrupt status |
| int_mask | output | 8 | Interrupt mask |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench allocates the whole pool, then checks allocation on an empty pool. A unit that leaked a number or reused an owned one would return a wrong or duplicate number. It also makes a receive claim and a host allocate meet in one cycle; a design without a second-choice picker would hand both sides the same buffer. The bench sends commands while `busy` is high and counts the busy cycles of a three-entry drain, which exposes an off-by-one hold or a command that slips through. It also sets junk bits below the command field, so a decoder that looked past bits 7:5 would act on the wrong command.

// File: rtl/pa_pkg.sv
package pa_pkg;
   typedef enum logic [2:0] {
      CMD_NOP      = 3'd0,
      CMD_ALLOC    = 3'd1,
      CMD_RESET    = 3'd2,
      CMD_RX_TAKE  = 3'd3,
      CMD_RX_FREE  = 3'd4,
      CMD_FREE_PNR = 3'd5,
      CMD_TX_PUSH  = 3'd6,
      CMD_TX_DRAIN = 3'd7
   } pa_cmd_e;

   localparam int IRQ_RX    = 0;
   localparam int IRQ_ALLOC = 3;
   localparam int IRQ_OVR   = 4;
endpackage

// File: rtl/pa_queue.sv
module pa_queue #(
   parameter int DEPTH = 4,
   parameter int W     = 2,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic          empty,
   output logic [CW-1:0] count
);
   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] rd_q, wr_q;
   logic [CW-1:0] cnt_q;
   logic          do_pop, do_push;

   function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign do_pop  = pop && (cnt_q != '0);
   assign do_push = push && ((cnt_q != CW'(DEPTH)) || do_pop);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else if (flush) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_pop)  rd_q <= nxt(rd_q);
         if (do_push) wr_q <= nxt(wr_q);
         cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wr_q] <= din;
   end

   assign head  = mem[rd_q];
   assign empty = (cnt_q == '0);
   assign count = cnt_q;

   p_no_overfill_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CW'(DEPTH) && push && !pop && !flush) |=> (cnt_q == CW'(DEPTH)));
endmodule

// File: rtl/pa_freemap.sv
module pa_freemap #(
   parameter int N   = 4,
   parameter int NW  = 2,
   localparam int CW = $clog2(N + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear_all,
   input  logic          claim_a,
   input  logic          claim_b,
   input  logic          rel_a,
   input  logic [NW-1:0] rel_a_num,
   input  logic          rel_b,
   input  logic [NW-1:0] rel_b_num,
   output logic [NW-1:0] pick_a,
   output logic          any_a,
   output logic [NW-1:0] pick_b,
   output logic          any_b,
   output logic [CW-1:0] nfree
);
   logic [N-1:0] free_q, rest, take, give;

   always_comb begin
      pick_a = '0;
      any_a  = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (free_q[i]) begin
            pick_a = NW'(i);
            any_a  = 1'b1;
         end
      end
      rest   = free_q & ~(any_a ? (N'(1) << pick_a) : '0);
      pick_b = '0;
      any_b  = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (rest[i]) begin
            pick_b = NW'(i);
            any_b  = 1'b1;
         end
      end
      nfree = '0;
      for (int i = 0; i < N; i++) nfree = nfree + CW'(free_q[i]);
   end

   always_comb begin
      take = '0;
      give = '0;
      if (claim_a && any_a) take = take | (N'(1) << pick_a);
      if (claim_b && any_b) take = take | (N'(1) << pick_b);
      if (rel_a) give = give | (N'(1) << rel_a_num);
      if (rel_b) give = give | (N'(1) << rel_b_num);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         free_q <= '1;
      else if (clear_all) free_q <= '1;
      else                free_q <= (free_q & ~take) | give;
   end

   p_two_distinct_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (any_a && any_b) |-> (pick_a != pick_b));
endmodule

// File: rtl/pkt_alloc_unit.sv
module pkt_alloc_unit #(
   parameter int NUM_PKTS = 4,
   parameter int REL_LAT  = 2,
   localparam int NW      = (NUM_PKTS > 1) ? $clog2(NUM_PKTS) : 1,
   localparam int CW      = $clog2(NUM_PKTS + 1),
   localparam int HW      = $clog2(REL_LAT + 1)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_valid,
   input  logic [7:0]  cmd_word,
   input  logic        pnr_wr,
   input  logic [7:0]  pnr_wdata,
   input  logic        mask_wr,
   input  logic [7:0]  mask_wdata,
   input  logic        ack_wr,
   input  logic [7:0]  ack_wdata,
   input  logic        rx_push,
   input  logic        tx_pop,
   output logic [7:0]  alloc_result,
   output logic [7:0]  pnr,
   output logic [15:0] fifo_status,
   output logic        busy,
   output logic [7:0]  int_status,
   output logic [7:0]  int_mask,
   output logic        irq
);
   import pa_pkg::*;

   if (NUM_PKTS < 2 || NUM_PKTS > 128) begin : g_bad_pool
      $error("NUM_PKTS must lie in 2..128");
   end
   if (REL_LAT < 1) begin : g_bad_lat
      $error("REL_LAT must be at least 1");
   end

   pa_cmd_e         cmd;
   logic            accept, is_alloc, is_reset, is_rx_take, is_rx_free;
   logic            is_free_pnr, is_tx_push, is_tx_drain;
   logic            pnr_ok, rx_take, rx_ovr, host_any, alloc_ok, tx_deq;
   logic [NW-1:0]   host_num, pick_a, pick_b, rx_head, tx_head, rel_a_num;
   logic            any_a, any_b, rx_empty, tx_empty, rel_a;
   logic [CW-1:0]   nfree, unused_rx_cnt, unused_tx_cnt;
   logic [HW-1:0]   hold_q;
   logic            drain_q, alloc_flag_q, ovr_flag_q;
   logic [7:0]      pnr_q, mask_q, res_q;
   logic [4:0]      unused_cmd_low;

   assign unused_cmd_low = cmd_word[4:0];
   assign cmd        = pa_cmd_e'(cmd_word[7:5]);
   assign accept     = cmd_valid && !busy;
   assign is_alloc    = accept && (cmd == CMD_ALLOC);
   assign is_reset    = accept && (cmd == CMD_RESET);
   assign is_rx_take  = accept && (cmd == CMD_RX_TAKE);
   assign is_rx_free  = accept && (cmd == CMD_RX_FREE);
   assign is_free_pnr = accept && (cmd == CMD_FREE_PNR);
   assign is_tx_push  = accept && (cmd == CMD_TX_PUSH);
   assign is_tx_drain = accept && (cmd == CMD_TX_DRAIN);

   assign pnr_ok   = (pnr_q < 8'(NUM_PKTS));
   assign rx_take  = rx_push && !is_reset && any_a;
   assign rx_ovr   = rx_push && !is_reset && !any_a;
   assign host_any = rx_take ? any_b : any_a;
   assign host_num = rx_take ? pick_b : pick_a;
   assign alloc_ok = is_alloc && host_any;
   assign tx_deq   = (drain_q || tx_pop) && !tx_empty;

   always_comb begin
      rel_a     = 1'b0;
      rel_a_num = rx_head;
      if (is_rx_free && !rx_empty) begin
         rel_a = 1'b1;
      end else if (is_free_pnr && pnr_ok) begin
         rel_a     = 1'b1;
         rel_a_num = pnr_q[NW-1:0];
      end
   end

   pa_freemap #(.N(NUM_PKTS), .NW(NW)) i_free (
      .clk(clk), .rst_n(rst_n), .clear_all(is_reset),
      .claim_a(rx_take || alloc_ok), .claim_b(alloc_ok && rx_take),
      .rel_a(rel_a), .rel_a_num(rel_a_num),
      .rel_b(tx_deq), .rel_b_num(tx_head),
      .pick_a(pick_a), .any_a(any_a), .pick_b(pick_b), .any_b(any_b),
      .nfree(nfree));

   pa_queue #(.DEPTH(NUM_PKTS), .W(NW)) i_rxq (
      .clk(clk), .rst_n(rst_n), .flush(is_reset),
      .push(rx_take), .din(pick_a), .pop(is_rx_take || is_rx_free),
      .head(rx_head), .empty(rx_empty), .count(unused_rx_cnt));

   pa_queue #(.DEPTH(NUM_PKTS), .W(NW)) i_txq (
      .clk(clk), .rst_n(rst_n), .flush(is_reset),
      .push(is_tx_push && pnr_ok), .din(pnr_q[NW-1:0]), .pop(tx_deq),
      .head(tx_head), .empty(tx_empty), .count(unused_tx_cnt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q       <= '0;
         drain_q      <= 1'b0;
         alloc_flag_q <= 1'b0;
         ovr_flag_q   <= 1'b0;
         pnr_q        <= '0;
         mask_q       <= '0;
         res_q        <= '0;
      end else begin
         if (is_reset || is_rx_free || is_free_pnr) hold_q <= HW'(REL_LAT);
         else if (hold_q != '0)                      hold_q <= hold_q - 1'b1;

         if (is_tx_drain)              drain_q <= 1'b1;
         else if (drain_q && tx_empty) drain_q <= 1'b0;

         if (alloc_ok)                           alloc_flag_q <= 1'b1;
         else if (is_alloc || is_reset)          alloc_flag_q <= 1'b0;
         else if (ack_wr && ack_wdata[IRQ_ALLOC]) alloc_flag_q <= 1'b0;

         if (rx_ovr)                             ovr_flag_q <= 1'b1;
         else if (is_reset)                      ovr_flag_q <= 1'b0;
         else if (ack_wr && ack_wdata[IRQ_OVR])  ovr_flag_q <= 1'b0;

         if (alloc_ok)      res_q <= {1'b0, 7'(host_num)};
         else if (is_alloc) res_q <= 8'h80;

         if (pnr_wr)  pnr_q  <= pnr_wdata;
         if (mask_wr) mask_q <= mask_wdata;
      end
   end

   assign busy         = (hold_q != '0) || drain_q;
   assign alloc_result = res_q;
   assign pnr          = pnr_q;
   assign int_mask     = mask_q;
   assign fifo_status  = {rx_empty, rx_empty ? 7'd0 : 7'(rx_head),
                          tx_empty, tx_empty ? 7'd0 : 7'(tx_head)};
   always_comb begin
      int_status            = '0;
      int_status[IRQ_RX]    = !rx_empty;
      int_status[IRQ_ALLOC] = alloc_flag_q;
      int_status[IRQ_OVR]   = ovr_flag_q;
   end
   assign irq = |(int_status & mask_q);

   p_alloc_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy && cmd_word[7:5] == 3'd1 && !rx_push && nfree != '0)
      |=> (int_status[3] && !alloc_result[7]));
   p_alloc_fail_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy && cmd_word[7:5] == 3'd1 && nfree == '0)
      |=> (alloc_result[7] && !int_status[3]));
   p_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && nfree == '0 && !(cmd_valid && !busy && cmd_word[7:5] == 3'd2))
      |=> int_status[4]);
   p_reset_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy && cmd_word[7:5] == 3'd2)
      |=> (fifo_status[15] && fifo_status[7] && nfree == CW'(NUM_PKTS)));
   p_drain_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy && cmd_word[7:5] == 3'd7) |=> busy);
   p_release_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy && (cmd_word[7:5] == 3'd2 || cmd_word[7:5] == 3'd4 ||
                              cmd_word[7:5] == 3'd5)) |=> busy);
   p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_valid && !rx_push) |=> $stable(alloc_result));
endmodule

// File: tb/test_pkt_alloc_unit.sv
module test_pkt_alloc_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 0, pnr_wr = 0, mask_wr = 0, ack_wr = 0;
   logic        rx_push = 0, tx_pop = 0;
   logic [7:0]  cmd_word = 0, pnr_wdata = 0, mask_wdata = 0, ack_wdata = 0;
   logic [7:0]  alloc_result, pnr, int_status, int_mask;
   logic [15:0] fifo_status;
   logic        busy, irq;
   int          checks = 0, errors = 0;
   bit          done = 0;

   always #2.5 clk = ~clk;

   pkt_alloc_unit #(.NUM_PKTS(4), .REL_LAT(2)) i_pkt_alloc_unit (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
      .pnr_wr(pnr_wr), .pnr_wdata(pnr_wdata), .mask_wr(mask_wr),
      .mask_wdata(mask_wdata), .ack_wr(ack_wr), .ack_wdata(ack_wdata),
      .rx_push(rx_push), .tx_pop(tx_pop), .alloc_result(alloc_result),
      .pnr(pnr), .fifo_status(fifo_status), .busy(busy),
      .int_status(int_status), .int_mask(int_mask), .irq(irq));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick(); @(negedge clk); endtask

   task automatic cmd(input logic [7:0] c);
      cmd_valid = 1; cmd_word = c; tick(); cmd_valid = 0; cmd_word = 0;
   endtask
   task automatic setp(input logic [7:0] v);
      pnr_wr = 1; pnr_wdata = v; tick(); pnr_wr = 0;
   endtask
   task automatic wait_idle();
      for (int i = 0; i < 20 && busy; i++) tick();
   endtask
   task automatic free_num(input logic [7:0] v);
      setp(v); cmd(8'hA0); wait_idle();
   endtask

   initial begin
      for (int i = 0; i < 20000; i++) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1;
      tick();
      chk("R8 reset fifo", fifo_status, 16'h8080);
      chk("R11 reset status", int_status, 8'h00);
      chk("R10 reset busy", busy, 0);
      chk("R2 reset result", alloc_result, 8'h00);

      for (int n = 0; n < 4; n++) begin
         cmd(8'h20);
         chk("R2 alloc number", alloc_result, 32'(n));
         chk("R2 alloc flag", int_status[3], 1);
      end
      cmd(8'h20);
      chk("R3 fail result", alloc_result, 8'h80);
      chk("R3 fail flag", int_status[3], 0);

      setp(8'd2);
      chk("R13 pnr readback", pnr, 8'd2);
      cmd(8'hC0);
      setp(8'd0);
      cmd(8'hC0);
      chk("R4 tx head", fifo_status, 16'h8002);
      tx_pop = 1; tick(); tx_pop = 0;
      chk("R4 tx next", fifo_status, 16'h8000);
      tx_pop = 1; tick(); tx_pop = 0;
      chk("R4 tx empty", fifo_status, 16'h8080);
      cmd(8'h20);
      chk("R4 freed by pop a", alloc_result, 8'h00);
      cmd(8'h20);
      chk("R4 freed by pop b", alloc_result, 8'h02);

      mask_wr = 1; mask_wdata = 8'h10; tick(); mask_wr = 0;
      rx_push = 1; tick(); rx_push = 0;
      chk("R5 overrun status", int_status, 8'h18);
      chk("R5 nothing queued", fifo_status, 16'h8080);
      chk("R11 irq masked on", irq, 1);
      ack_wr = 1; ack_wdata = 8'h18; tick(); ack_wr = 0;
      chk("R11 ack clears", int_status, 8'h00);
      chk("R11 irq off", irq, 0);

      setp(8'd1);
      cmd(8'hA0);
      chk("R10 busy after free", busy, 1);
      cmd(8'h20);
      chk("R10 ignored while busy", alloc_result, 8'h02);
      chk("R10 ignored flag", int_status[3], 0);
      tick();
      chk("R10 busy length", busy, 0);
      cmd(8'h20);
      chk("R7 freed number reused", alloc_result, 8'h01);

      free_num(8'd3);
      free_num(8'd0);
      rx_push = 1; cmd_valid = 1; cmd_word = 8'h20; tick();
      rx_push = 0; cmd_valid = 0; cmd_word = 0;
      chk("R12 host gets second", alloc_result, 8'h03);
      chk("R12 rx gets lowest", fifo_status, 16'h0080);
      chk("R11 rx status", int_status, 8'h09);
      mask_wr = 1; mask_wdata = 8'h01; tick(); mask_wr = 0;
      chk("R11 irq rx", irq, 1);

      free_num(8'd1);
      rx_push = 1; tick(); rx_push = 0;
      chk("R5 rx order", fifo_status, 16'h0080);
      cmd(8'h60);
      chk("R6 take head", fifo_status, 16'h0180);
      cmd(8'h20);
      chk("R6 taken not freed", alloc_result, 8'h80);
      cmd(8'h80);
      chk("R6 remove free empty", fifo_status, 16'h8080);
      wait_idle();
      cmd(8'h20);
      chk("R6 freed head reused", alloc_result, 8'h01);

      for (int n = 0; n < 3; n++) begin setp(8'(n)); cmd(8'hC0); end
      chk("R9 queued", fifo_status, 16'h8000);
      cmd(8'hE0);
      begin
         int cnt = 0;
         for (int i = 0; i < 10 && busy; i++) begin cnt++; tick(); end
         chk("R9 drain busy cycles", cnt, 4);
      end
      chk("R9 drained", fifo_status, 16'h8080);
      for (int n = 0; n < 3; n++) begin
         cmd(8'h20);
         chk("R9 drained freed", alloc_result, 32'(n));
      end
      cmd(8'h20);
      chk("R9 owned kept", alloc_result, 8'h80);

      cmd(8'h20);
      cmd(8'h5F);
      chk("R8 cmd reset fifo", fifo_status, 16'h8080);
      chk("R8 cmd reset status", int_status, 8'h00);
      wait_idle();
      cmd(8'h2A);
      chk("R1 alloc low junk", alloc_result, 8'h00);
      cmd(8'h1F);
      chk("R1 nop low junk", alloc_result, 8'h00);
      chk("R1 nop busy", busy, 0);
      cmd(8'h3F);
      chk("R1 alloc all junk", alloc_result, 8'h01);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule